// File: doc/BRIEF.md
# ADC Conversion Phase Sequencer

This block drives an external successive-approximation converter through its per-channel timing. A 16-bit divide value sets the length of three consecutive phases, all counted in peripheral clock cycles: analog switch settling, converter setup (idle) and conversion. The short phases use only the low six bits of the divide value. The setup phase uses all sixteen bits. After the conversion phase the block spends one capture cycle sampling the 10-bit result. It then compares that result against a lower and an upper bound.

Software programs the divide value, a channel mask and the two bounds through a small write port, and then pulses `start`. The block walks the selected channels from the lowest bit upward. For each channel it runs the full three-phase sequence and reports one result. It pulses `done` after the last channel. The states are IDLE, SWITCH, SETUP, CONVERT, CAPTURE and DONE. The transitions are:

- IDLE to SWITCH, on start with a non-empty mask.
- IDLE to DONE, on start with an empty mask.
- SWITCH to SETUP, when the phase count runs out.
- SETUP to CONVERT, when the phase count runs out.
- CONVERT to CAPTURE, when the phase count runs out.
- CAPTURE to SWITCH, while channels remain.
- CAPTURE to DONE, after the last channel.
- DONE to IDLE, always.

One down-counter times every phase. It is reloaded at each phase boundary.

Top module: `adc_phase_seq`

## Requirements
- R1: While the switch-settling strobe `sw_en` is high, it lasts exactly (DIV[5:0] + 3) * 2 cycles per channel.
- R2: The setup strobe `setup_en` lasts exactly (DIV[15:0] + 1) * 2 cycles per channel.
- R3: The conversion strobe `conv_en` lasts exactly (DIV[5:0] + 1) * 24 cycles per channel.
- R4: For each channel the phases follow this order: switch, then setup, then conversion, then one capture cycle. Only one strobe is high at a time. `ch_sel` is the one-hot code of the current channel and stays steady through that channel's phases.
- R5: Selected channels are processed in ascending bit order, with exactly one result per selected bit. `res_valid` pulses for one cycle carrying `res_chan` (the bit index) and `res_data` (the value of `adc_data` sampled in the capture cycle). `done` is a one-cycle pulse that follows the last channel.
- R6: `res_oow` is 1 when the result is below the lower bound or above the upper bound. A result equal to either bound gives 0.
- R7: If the mask is zero when `start` is pulsed, `done` is high in the next cycle and no strobe rises.
- R8: A `start` pulse during a running sequence is ignored. The sequence keeps its phase counts and its channel list, and produces a single `done`.
- R9: The write port selects a field by `wr_sel`: 0 is the divide value (`wr_data[15:0]`), 1 is the channel mask (`wr_data[NCH-1:0]`), 2 is the upper bound (`wr_data[9:0]`) and 3 is the lower bound (`wr_data[9:0]`). Reset sets the divide value to 0xFFFF and the mask and both bounds to 0. It also drops all strobes, `ch_sel`, `res_valid` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Field select for the write |
| wr_data | input | DIVW | Write data |
| start | input | 1 | Start pulse for a sequence |
| ch_sel | output | NCH | One-hot code of the active channel |
| sw_en | output | 1 | Analog switch settling phase |
| setup_en | output | 1 | Converter setup phase |
| conv_en | output | 1 | Conversion phase |
| adc_data | input | DW | Result from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | CHW | Channel index of the result |
| res_data | output | DW | Captured result |
| res_oow | output | 1 | Result lies outside the window |
| done | output | 1 | Sequence finished pulse |

## Verification
The bench builds the block with NCH = 4, DW = 10 and DIVW = 16. With four channels the full mask 4'hF can be reached, along with the ascending order across gaps such as 4'b1010. Divide values such as 0x0040 and 0x0045 have short low fields but larger full values, which separates the six-bit phases from the sixteen-bit setup phase. The reset divide value of 0xFFFF is checked through the 132-cycle switch phase it produces.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWITCH,
        ST_SETUP,
        ST_CONVERT,
        ST_CAPTURE,
        ST_DONE
    } seq_state_e;

    localparam int SEL_DIV   = 0;
    localparam int SEL_MASK  = 1;
    localparam int SEL_UPPER = 2;
    localparam int SEL_LOWER = 3;
endpackage

// File: rtl/adc_phase_len.sv
module adc_phase_len #(
    parameter int DIVW    = 16,
    parameter int SHW     = 6,
    parameter int SW_OFS  = 3,
    parameter int SW_MUL  = 2,
    parameter int SU_OFS  = 1,
    parameter int SU_MUL  = 2,
    parameter int CV_OFS  = 1,
    parameter int CV_MUL  = 24,
    parameter int CW      = DIVW + 2
) (
    input  logic [DIVW-1:0] div,
    output logic [CW-1:0]   sw_len,
    output logic [CW-1:0]   setup_len,
    output logic [CW-1:0]   conv_len
);
    logic [CW-1:0] short_f;
    logic [CW-1:0] full_f;

    assign short_f   = CW'(div[SHW-1:0]);
    assign full_f    = CW'(div);
    assign sw_len    = CW'((short_f + CW'(SW_OFS)) * CW'(SW_MUL));
    assign setup_len = CW'((full_f + CW'(SU_OFS)) * CW'(SU_MUL));
    assign conv_len  = CW'((short_f + CW'(CV_OFS)) * CW'(CV_MUL));
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign last = (cnt == CW'(1));
endmodule

// File: rtl/adc_low_pick.sv
module adc_low_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx
);
    assign onehot = vec & (~vec + N'(1));

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp #(
    parameter int DW = 10
) (
    input  logic [DW-1:0] value,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    output logic          outside
);
    assign outside = (value < lo) || (value > hi);
endmodule

// File: rtl/adc_phase_seq.sv
module adc_phase_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int DW   = 10,
    parameter int DIVW = 16,
    parameter int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [DIVW-1:0] wr_data,
    input  logic            start,
    output logic [NCH-1:0]  ch_sel,
    output logic            sw_en,
    output logic            setup_en,
    output logic            conv_en,
    input  logic [DW-1:0]   adc_data,
    output logic            res_valid,
    output logic [CHW-1:0]  res_chan,
    output logic [DW-1:0]   res_data,
    output logic            res_oow,
    output logic            done
);
    localparam int CW = DIVW + 2;
    localparam logic [DIVW-1:0] DIV_RST = {DIVW{1'b1}};

    seq_state_e      state_q, state_d;
    logic [DIVW-1:0] div_q;
    logic [NCH-1:0]  mask_q;
    logic [DW-1:0]   upper_q, lower_q;
    logic [NCH-1:0]  pend_q, pend_d;
    logic [NCH-1:0]  low_oh;
    logic [CHW-1:0]  low_idx;
    logic [CW-1:0]   sw_len, setup_len, conv_len;
    logic [CW-1:0]   tmr_val, tmr_cnt;
    logic            tmr_load, tmr_last;
    logic            capture, outside;
    logic            seq_idle;

    // configuration fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= DIV_RST;
            mask_q  <= '0;
            upper_q <= '0;
            lower_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                2'(SEL_DIV):   div_q   <= wr_data;
                2'(SEL_MASK):  mask_q  <= wr_data[NCH-1:0];
                2'(SEL_UPPER): upper_q <= wr_data[DW-1:0];
                2'(SEL_LOWER): lower_q <= wr_data[DW-1:0];
                default:       ;
            endcase
        end
    end

    adc_phase_len #(.DIVW(DIVW), .CW(CW)) u_len (
        .div       (div_q),
        .sw_len    (sw_len),
        .setup_len (setup_len),
        .conv_len  (conv_len)
    );

    adc_phase_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .last     (tmr_last)
    );

    adc_low_pick #(.N(NCH), .IW(CHW)) u_pick (
        .vec    (pend_q),
        .onehot (low_oh),
        .idx    (low_idx)
    );

    adc_window_cmp #(.DW(DW)) u_win (
        .value   (adc_data),
        .lo      (lower_q),
        .hi      (upper_q),
        .outside (outside)
    );

    // next state and phase reloads
    always_comb begin
        state_d  = state_q;
        pend_d   = pend_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (mask_q == '0) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d  = ST_SWITCH;
                        pend_d   = mask_q;
                        tmr_load = 1'b1;
                        tmr_val  = sw_len;
                    end
                end
            end
            ST_SWITCH: begin
                if (tmr_last) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = setup_len;
                end
            end
            ST_SETUP: begin
                if (tmr_last) begin
                    state_d  = ST_CONVERT;
                    tmr_load = 1'b1;
                    tmr_val  = conv_len;
                end
            end
            ST_CONVERT: begin
                if (tmr_last) state_d = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                capture = 1'b1;
                pend_d  = pend_q & ~low_oh;
                if (pend_d == '0) begin
                    state_d = ST_DONE;
                end else begin
                    state_d  = ST_SWITCH;
                    tmr_load = 1'b1;
                    tmr_val  = sw_len;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_chan  <= '0;
            res_data  <= '0;
            res_oow   <= 1'b0;
        end else begin
            res_valid <= capture;
            if (capture) begin
                res_chan <= low_idx;
                res_data <= adc_data;
                res_oow  <= outside;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        sw_en    = 1'b0;
        setup_en = 1'b0;
        conv_en  = 1'b0;
        done     = 1'b0;
        ch_sel   = '0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_SWITCH:  begin sw_en    = 1'b1; ch_sel = low_oh; end
            ST_SETUP:   begin setup_en = 1'b1; ch_sel = low_oh; end
            ST_CONVERT: begin conv_en  = 1'b1; ch_sel = low_oh; end
            ST_CAPTURE: ch_sel = low_oh;
            ST_DONE:    done = 1'b1;
            default:    ;
        endcase
    end

    assign seq_idle = (state_q == ST_IDLE);
endmodule

// File: rtl/adc_phase_seq_chk.sv
module adc_phase_seq_chk #(
    parameter int NCH = 8,
    parameter int CW  = 18
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           sw_en,
    input logic           setup_en,
    input logic           conv_en,
    input logic           done,
    input logic [NCH-1:0] ch_sel,
    input logic [NCH-1:0] mask_q,
    input logic [CW-1:0]  tmr_cnt,
    input logic           seq_idle
);
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_en, setup_en, conv_en}));

    p_switch_then_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_en) |-> setup_en);

    p_setup_then_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(setup_en) |-> conv_en);

    p_chsel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en || setup_en || conv_en) |-> $onehot(ch_sel));

    p_chsel_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_en || conv_en) |-> $stable(ch_sel));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && start && mask_q == '0) |=> done);

    p_busy_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_en && start) |=> (setup_en || conv_en));

    p_timer_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en || setup_en || conv_en) |-> (tmr_cnt != '0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_idle |-> (ch_sel == '0 && !done));
endmodule

bind adc_phase_seq adc_phase_seq_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sw_en    (sw_en),
    .setup_en (setup_en),
    .conv_en  (conv_en),
    .done     (done),
    .ch_sel   (ch_sel),
    .mask_q   (mask_q),
    .tmr_cnt  (tmr_cnt),
    .seq_idle (seq_idle)
);

// File: tb/test_adc_phase_seq.sv
module test_adc_phase_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 4;
    localparam int DW   = 10;
    localparam int DIVW = 16;
    localparam int CHW  = 2;
    localparam int NVEC = 6;
    localparam int RUN_LIMIT = 20000;

    // fields: div[49:34] mask[33:30] upper[29:20] lower[19:10] adc[9:0]
    localparam logic [49:0] VEC [NVEC] = '{
        {16'h0001, 4'b0001, 10'h200, 10'h100, 10'h180},
        {16'h0040, 4'b1010, 10'h200, 10'h100, 10'h100},
        {16'h0002, 4'b1111, 10'h200, 10'h100, 10'h200},
        {16'h0003, 4'b0110, 10'h200, 10'h100, 10'h0FF},
        {16'h0001, 4'b1000, 10'h200, 10'h100, 10'h201},
        {16'h0045, 4'b0101, 10'h3FF, 10'h000, 10'h3FF}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_sel = '0;
    logic [DIVW-1:0] wr_data = '0;
    logic            start = 1'b0;
    logic [NCH-1:0]  ch_sel;
    logic            sw_en, setup_en, conv_en;
    logic [DW-1:0]   adc_data = '0;
    logic            res_valid;
    logic [CHW-1:0]  res_chan;
    logic [DW-1:0]   res_data;
    logic            res_oow;
    logic            done;

    int n_checks = 0;
    int n_bad = 0;
    int n_cycles = 0;
    bit finished = 1'b0;

    int n_sw, n_su, n_cv, n_res, n_order_err, n_chsel_err, n_chan_err;
    int n_data_err, n_oow_err, run_cyc, n_after;
    bit saw_done;

    adc_phase_seq #(.NCH(NCH), .DW(DW), .DIVW(DIVW)) i_adc_phase_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .start(start), .ch_sel(ch_sel), .sw_en(sw_en),
        .setup_en(setup_en), .conv_en(conv_en), .adc_data(adc_data),
        .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
        .res_oow(res_oow), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int len_sw(input int d);
        return ((d % 64) + 3) * 2;
    endfunction
    function automatic int len_su(input int d);
        return (d + 1) * 2;
    endfunction
    function automatic int len_cv(input int d);
        return ((d % 64) + 1) * 24;
    endfunction

    task automatic write_reg(input int sel, input int val);
        wr_en = 1'b1;
        wr_sel = 2'(sel);
        wr_data = DIVW'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // called at a negedge; runs one sequence and gathers observations
    task automatic run_seq(input logic [NCH-1:0] m, input logic [DW-1:0] lo,
                           input logic [DW-1:0] hi, input bit repulse);
        logic [NCH-1:0] left;
        int last_ph, ph;
        bit exp_oow;
        left = m;
        last_ph = 0;
        n_sw = 0; n_su = 0; n_cv = 0; n_res = 0; n_order_err = 0;
        n_chsel_err = 0; n_chan_err = 0; n_data_err = 0; n_oow_err = 0;
        run_cyc = 0; saw_done = 1'b0; n_after = 0;
        exp_oow = (adc_data < lo) || (adc_data > hi);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (run_cyc < RUN_LIMIT) begin
            if (res_valid) begin
                logic [NCH-1:0] oh;
                int want;
                oh = left & (~left + NCH'(1));
                want = 0;
                for (int i = NCH - 1; i >= 0; i--) if (oh[i]) want = i;
                if (int'(res_chan) != want || left == '0) n_chan_err++;
                if (res_data != adc_data) n_data_err++;
                if (res_oow != exp_oow) n_oow_err++;
                left = left & ~oh;
                n_res++;
            end
            ph = sw_en ? 1 : setup_en ? 2 : conv_en ? 3 : 0;
            if (sw_en) n_sw++;
            if (setup_en) n_su++;
            if (conv_en) n_cv++;
            if (ph != 0 && ph != last_ph) begin
                if (!((ph == 1 && (last_ph == 0 || last_ph == 3)) || ph == last_ph + 1))
                    n_order_err++;
                last_ph = ph;
            end
            if (ph != 0 && ch_sel != (left & (~left + NCH'(1)))) n_chsel_err++;
            if (done) begin
                saw_done = 1'b1;
                break;
            end
            start = repulse && (run_cyc == 5 || run_cyc == 40);
            @(negedge clk);
            start = 1'b0;
            run_cyc++;
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (done || sw_en || setup_en || conv_en || res_valid) n_after++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state of outputs
        chk(!sw_en && !setup_en && !conv_en, "R9 strobes after reset", int'({sw_en, setup_en, conv_en}), 0);
        chk(ch_sel == '0 && !done && !res_valid, "R9 ch_sel/done after reset", int'(ch_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 mask resets to zero: start gives done at once
        run_seq('0, '0, '0, 1'b0);
        chk(saw_done && run_cyc == 0, "R9 R7 reset mask empty -> immediate done", run_cyc, 0);

        // R9 divide resets to 0xFFFF: switch phase is (63+3)*2
        write_reg(1, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n_sw = 0;
        while (sw_en && n_sw < 1000) begin
            n_sw++;
            @(negedge clk);
        end
        chk(n_sw == 132, "R9 R1 default divide switch length", n_sw, 132);
        chk(setup_en, "R9 setup follows switch", int'(setup_en), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!setup_en && ch_sel == '0, "R9 reset aborts sequence", int'(setup_en), 0);

        // R9 bounds reset to 0: value 0 inside, value 1 outside
        write_reg(0, 1);
        write_reg(1, 1);
        adc_data = 10'd0;
        run_seq(4'b0001, 10'd0, 10'd0, 1'b0);
        chk(n_res == 1 && n_oow_err == 0, "R9 R6 reset bounds, value 0 inside", n_oow_err, 0);
        adc_data = 10'd1;
        run_seq(4'b0001, 10'd0, 10'd0, 1'b0);
        chk(n_res == 1 && n_oow_err == 0, "R9 R6 reset bounds, value 1 outside", n_oow_err, 0);

        // table of vectors
        for (int v = 0; v < NVEC; v++) begin
            int d, nc;
            logic [NCH-1:0] m;
            logic [DW-1:0] hi, lo;
            d  = int'(VEC[v][49:34]);
            m  = VEC[v][33:30];
            hi = VEC[v][29:20];
            lo = VEC[v][19:10];
            nc = $countones(m);
            write_reg(0, d);
            write_reg(1, int'(m));
            write_reg(2, int'(hi));
            write_reg(3, int'(lo));
            adc_data = VEC[v][9:0];
            run_seq(m, lo, hi, v == 2 || v == 5);
            chk(n_sw == nc * len_sw(d), "R1 switch cycles", n_sw, nc * len_sw(d));
            chk(n_su == nc * len_su(d), "R2 setup cycles", n_su, nc * len_su(d));
            chk(n_cv == nc * len_cv(d), "R3 conversion cycles", n_cv, nc * len_cv(d));
            chk(n_order_err == 0 && n_chsel_err == 0, "R4 phase order and ch_sel", n_order_err + n_chsel_err, 0);
            chk(n_res == nc && n_chan_err == 0 && n_data_err == 0, "R5 results ascending", n_res, nc);
            chk(saw_done && n_after == 0, "R5 R8 single done pulse", n_after, 0);
            chk(n_oow_err == 0, "R6 window flag", n_oow_err, 0);
        end

        // R7 empty mask with non-default divide
        write_reg(1, 0);
        run_seq('0, '0, '0, 1'b0);
        chk(saw_done && run_cyc == 0 && n_sw == 0, "R7 empty mask done next cycle", run_cyc, 0);
        chk(n_after == 0, "R7 no phase after empty start", n_after, 0);

        // R8 start repeated every few cycles while busy
        write_reg(0, 2);
        write_reg(1, 3);
        run_seq(4'b0011, 10'h100, 10'h200, 1'b1);
        chk(n_sw == 2 * len_sw(2) && n_res == 2, "R8 restart ignored", n_sw, 2 * len_sw(2));

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        n_cycles++;
        if (n_cycles > 150000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", n_cycles, 150000);
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule